// File: doc/BRIEF.md
# Triggered Event Record Builder

The builder sits after a trigger decision stage that produces one result per bunch crossing, one crossing per clock. Every crossing's identifier, downscale mode, six 10-bit measurement values and 15-bit report enter a short shift pipeline. The pipeline keeps the two crossings before and the two after the one in its middle stage. When the middle crossing carries a positive decision, a 32-word record is assembled from the whole window and the running counters. The record is written into a record queue in a single cycle.

Queued records leave on a ready/valid word stream, one 32-bit word per accepted transfer, oldest record first. A flag goes high when the queue is close to full. When the queue is full, a triggered record is discarded and a drop counter is incremented. The drop count travels inside later records.

Top module: `evrec_builder`

## Requirements
- R1: A crossing whose report bit 0 (decision) is 1 is captured on the third rising edge after the edge that sampled it. From the cycle after the capture, `out_valid` is high whenever at least one record is queued. Crossings with decision 0 produce no record. After reset the pipeline holds five empty crossings.
- R2: Each record leaves as 32 words, word 0 first, one word per cycle in which `out_valid` and `out_ready` are both high. `out_last` marks word 31. While `out_ready` is low, `out_data` and the word position stay unchanged.
- R3: Word 0 carries the triggered crossing's 3-bit downscale mode in bits 2:0. Word 1 carries its 12-bit crossing identifier in bits 11:0. All other bits of both words are 0.
- R4: Words 2 to 7 carry, in bits 9:0, the triggered crossing's values in this order: hadron 1, hadron 2, total energy, multiplicity, muon, electron. Word 8 carries the largest of hadron 1, hadron 2, muon and electron.
- R5: Words 14 to 18 carry the 16-bit reports of crossings N-2, N-1, N, N+1 and N+2 in bits 15:0. In each report, bits 14:0 are `rpt_in` as sampled. Bit 15 is the value of `fifo_warn` in the cycle the crossing was sampled. Within `rpt_in`, bit 0 is the decision and bits 1, 3, 5, 7 are the electron, single-hadron, two-hadron and muon triggers. Bits 2, 4, 6, 8 are their downscaled forms, bit 9 is forced, bit 13 is the sync error and bit 14 is the data error.
- R6: Word 19 holds the total energy of N-2 in bits 25:16 and that of N-1 in bits 9:0. Word 20 holds N+1 in bits 25:16 and N+2 in bits 9:0. All other bits are 0.
- R7: Words 21 to 26 carry six counters. All are cleared by reset and include every crossing sampled up to and including N+2.
  - Word 21 counts decided crossings with a normal trigger bit set.
  - Word 22 counts decided crossings with a downscaled bit set.
  - Word 23 counts decided crossings with the forced bit set.
  - Word 24 counts crossings with the sync error bit set.
  - Word 25 counts crossings with the data error bit set.
  - Word 26 counts earlier captures made while `fifo_warn` was high.
- R8: Words 10 to 13 and 27 to 31 are 0.
- R9: The queue holds at most 16 records. A capture that finds 16 records queued is discarded and increments a drop counter. Word 9 of every later record carries this counter.
- R10: `fifo_warn` is high exactly while 12 or more records are queued. A record stops counting once its word 31 is accepted.
- R11: After reset `out_valid` and `fifo_warn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rst | input | 1 | Synchronous active-high reset |
| xid_in | input | 12 | Crossing identifier |
| mode_in | input | 3 | Downscale mode of the crossing |
| h1_in | input | 10 | Highest hadron energy |
| h2_in | input | 10 | Second hadron energy |
| et_in | input | 10 | Total energy |
| mult_in | input | 10 | Multiplicity |
| mu_in | input | 10 | Highest muon momentum |
| el_in | input | 10 | Highest electron energy |
| rpt_in | input | 15 | Per-crossing report bits 14:0 |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | A record word is presented |
| out_data | output | 32 | Record word |
| out_last | output | 1 | Presented word is word 31 |
| fifo_warn | output | 1 | Twelve or more records queued |

## Verification
The bench runs three kinds of traffic: sparse triggers with a mostly ready sink, a dense burst into a blocked sink, and a final drain. The burst drives the queue past the warning level and into repeated drops. A design that wrote into a full queue would corrupt a stored record. A design that counted drops wrongly would show a wrong word 9. Back-to-back decisions check that the neighbour reports and energy pairs take the right window slots; an off-by-one stage would shift words 14 to 20 by one crossing. Long stalls in the middle of a record catch a design that advances the word position without a transfer. The warning's fall is checked against the acceptance of word 31, which catches a design that releases the slot on the first word.

// File: rtl/evrec_pkg.sv
package evrec_pkg;

    localparam int WORD_W    = 32;
    localparam int REC_WORDS = 32;
    localparam int REC_BITS  = WORD_W * REC_WORDS;
    localparam int VAL_W     = 10;
    localparam int RPT_W     = 16;
    localparam int XID_W     = 12;
    localparam int MODE_W    = 3;
    localparam int N_BEFORE  = 2;
    localparam int N_AFTER   = 2;
    localparam int WIN       = N_BEFORE + N_AFTER + 1;
    localparam int HALF_W    = WORD_W / 2;

    // report bit positions
    localparam int RB_DEC  = 0;
    localparam int RB_EL   = 1;
    localparam int RB_ELD  = 2;
    localparam int RB_H1   = 3;
    localparam int RB_H1D  = 4;
    localparam int RB_H2   = 5;
    localparam int RB_H2D  = 6;
    localparam int RB_MU   = 7;
    localparam int RB_MUD  = 8;
    localparam int RB_FRC  = 9;
    localparam int RB_SYNC = 13;
    localparam int RB_DERR = 14;
    localparam int RB_WARN = 15;

    // record slots
    localparam int SLOT_HDR  = 0;
    localparam int SLOT_XID  = 1;
    localparam int SLOT_VAL  = 2;
    localparam int SLOT_MAX  = 8;
    localparam int SLOT_DROP = 9;
    localparam int SLOT_RPT  = 14;
    localparam int SLOT_EPRE = 19;
    localparam int SLOT_EPST = 20;
    localparam int SLOT_CNT  = 21;

    typedef struct packed {
        logic [XID_W-1:0]  xid;
        logic [MODE_W-1:0] mode;
        logic [VAL_W-1:0]  h1;
        logic [VAL_W-1:0]  h2;
        logic [VAL_W-1:0]  et;
        logic [VAL_W-1:0]  mult;
        logic [VAL_W-1:0]  mu;
        logic [VAL_W-1:0]  el;
        logic [RPT_W-1:0]  rpt;
    } xing_t;

    typedef struct packed {
        logic [WORD_W-1:0] normal;
        logic [WORD_W-1:0] downs;
        logic [WORD_W-1:0] forced;
        logic [WORD_W-1:0] sync_err;
        logic [WORD_W-1:0] data_err;
        logic [WORD_W-1:0] warned;
        logic [WORD_W-1:0] dropped;
    } tally_t;

    function automatic logic [VAL_W-1:0] max4(input logic [VAL_W-1:0] a, b, c, d);
        logic [VAL_W-1:0] m1, m2;
        m1 = (a > b) ? a : b;
        m2 = (c > d) ? c : d;
        return (m1 > m2) ? m1 : m2;
    endfunction

    function automatic logic [WORD_W-1:0] zx(input logic [VAL_W-1:0] v);
        return {{(WORD_W-VAL_W){1'b0}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] pair(input logic [VAL_W-1:0] hi, lo);
        return {{(HALF_W-VAL_W){1'b0}}, hi, {(HALF_W-VAL_W){1'b0}}, lo};
    endfunction

endpackage

// File: rtl/evrec_xing_pipe.sv
module evrec_xing_pipe
    import evrec_pkg::*;
#(
    parameter int STAGES = WIN
) (
    input  logic                clk,
    input  logic                rst,
    input  xing_t               x_in,
    output xing_t [STAGES-1:0]  x_stage
);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_stage <= '0;
        end else begin
            x_stage[0] <= x_in;
            for (int i = 1; i < STAGES; i++) begin
                x_stage[i] <= x_stage[i-1];
            end
        end
    end

endmodule

// File: rtl/evrec_tally.sv
module evrec_tally
    import evrec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xing_t  x_new,
    input  logic   cap,
    input  logic   warn_now,
    input  logic   full_now,
    output tally_t tally
);

    logic dec, any_norm, any_down;

    always_comb begin
        dec      = x_new.rpt[RB_DEC];
        any_norm = x_new.rpt[RB_EL]  | x_new.rpt[RB_H1]  | x_new.rpt[RB_H2]  | x_new.rpt[RB_MU];
        any_down = x_new.rpt[RB_ELD] | x_new.rpt[RB_H1D] | x_new.rpt[RB_H2D] | x_new.rpt[RB_MUD];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tally <= '0;
        end else begin
            if (dec && any_norm)           tally.normal   <= tally.normal + 1'b1;
            if (dec && any_down)           tally.downs    <= tally.downs + 1'b1;
            if (dec && x_new.rpt[RB_FRC])  tally.forced   <= tally.forced + 1'b1;
            if (x_new.rpt[RB_SYNC])        tally.sync_err <= tally.sync_err + 1'b1;
            if (x_new.rpt[RB_DERR])        tally.data_err <= tally.data_err + 1'b1;
            if (cap && warn_now)           tally.warned   <= tally.warned + 1'b1;
            if (cap && full_now)           tally.dropped  <= tally.dropped + 1'b1;
        end
    end

    // R7
    tally_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tally.normal - $past(tally.normal)) <= 32'd1);

    // R9
    drop_only_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (tally.dropped != $past(tally.dropped)) |-> $past(full_now));

endmodule

// File: rtl/evrec_format.sv
module evrec_format
    import evrec_pkg::*;
(
    input  xing_t [WIN-1:0]      win,
    input  tally_t               tally,
    output logic [REC_BITS-1:0]  rec
);

    logic [WORD_W-1:0] w [REC_WORDS];
    xing_t ctr;

    always_comb begin
        ctr = win[N_AFTER];
        for (int i = 0; i < REC_WORDS; i++) begin
            w[i] = '0;
        end
        w[SLOT_HDR]    = {{(WORD_W-MODE_W){1'b0}}, ctr.mode};
        w[SLOT_XID]    = {{(WORD_W-XID_W){1'b0}}, ctr.xid};
        w[SLOT_VAL+0]  = zx(ctr.h1);
        w[SLOT_VAL+1]  = zx(ctr.h2);
        w[SLOT_VAL+2]  = zx(ctr.et);
        w[SLOT_VAL+3]  = zx(ctr.mult);
        w[SLOT_VAL+4]  = zx(ctr.mu);
        w[SLOT_VAL+5]  = zx(ctr.el);
        w[SLOT_MAX]    = zx(max4(ctr.h1, ctr.h2, ctr.mu, ctr.el));
        w[SLOT_DROP]   = tally.dropped;
        for (int k = 0; k < WIN; k++) begin
            w[SLOT_RPT+k] = {{(WORD_W-RPT_W){1'b0}}, win[WIN-1-k].rpt};
        end
        w[SLOT_EPRE]   = pair(win[WIN-1].et, win[WIN-2].et);
        w[SLOT_EPST]   = pair(win[1].et, win[0].et);
        w[SLOT_CNT+0]  = tally.normal;
        w[SLOT_CNT+1]  = tally.downs;
        w[SLOT_CNT+2]  = tally.forced;
        w[SLOT_CNT+3]  = tally.sync_err;
        w[SLOT_CNT+4]  = tally.data_err;
        w[SLOT_CNT+5]  = tally.warned;
    end

    for (genvar i = 0; i < REC_WORDS; i++) begin : g_pack
        assign rec[i*WORD_W +: WORD_W] = w[i];
    end

endmodule

// File: rtl/evrec_fifo.sv
module evrec_fifo
    import evrec_pkg::*;
#(
    parameter int RECS    = 16,
    parameter int WARN_AT = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  logic [REC_BITS-1:0]  push_rec,
    output logic                 full,
    output logic                 warn,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_data,
    output logic                 out_last
);

    localparam int PW = (RECS > 1) ? $clog2(RECS) : 1;
    localparam int CW = $clog2(RECS + 1);
    localparam int IW = $clog2(REC_WORDS);

    logic [REC_BITS-1:0] store [RECS];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [IW-1:0] widx;
    logic accept, fire, done;

    always_comb begin
        full      = (cnt == CW'(RECS));
        warn      = (cnt >= CW'(WARN_AT));
        out_valid = (cnt != '0);
        out_last  = out_valid && (widx == IW'(REC_WORDS - 1));
        out_data  = store[rp][int'(widx)*WORD_W +: WORD_W];
        accept    = push && !full;
        fire      = out_valid && out_ready;
        done      = fire && out_last;
    end

    always_ff @(posedge clk) begin
        if (accept) store[wp] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            widx <= '0;
        end else begin
            if (accept) wp <= (wp == PW'(RECS - 1)) ? '0 : wp + 1'b1;
            if (fire) widx <= done ? '0 : widx + 1'b1;
            if (done) rp <= (rp == PW'(RECS - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(accept) - CW'(done);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(RECS));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10
    warn_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(warn) |-> $past(accept));

    // R10
    warn_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(warn) |-> $past(done));

endmodule

// File: rtl/evrec_builder.sv
module evrec_builder
    import evrec_pkg::*;
#(
    parameter int RECS    = 16,
    parameter int WARN_AT = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [XID_W-1:0]    xid_in,
    input  logic [MODE_W-1:0]   mode_in,
    input  logic [VAL_W-1:0]    h1_in,
    input  logic [VAL_W-1:0]    h2_in,
    input  logic [VAL_W-1:0]    et_in,
    input  logic [VAL_W-1:0]    mult_in,
    input  logic [VAL_W-1:0]    mu_in,
    input  logic [VAL_W-1:0]    el_in,
    input  logic [RPT_W-2:0]    rpt_in,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    output logic                out_last,
    output logic                fifo_warn
);

    xing_t               x_in;
    xing_t [WIN-1:0]     win;
    tally_t              tally;
    logic [REC_BITS-1:0] rec;
    logic                cap, full;

    always_comb begin
        x_in.xid  = xid_in;
        x_in.mode = mode_in;
        x_in.h1   = h1_in;
        x_in.h2   = h2_in;
        x_in.et   = et_in;
        x_in.mult = mult_in;
        x_in.mu   = mu_in;
        x_in.el   = el_in;
        x_in.rpt  = {fifo_warn, rpt_in};
        cap       = win[N_AFTER].rpt[RB_DEC];
    end

    evrec_xing_pipe #(.STAGES(WIN)) u_pipe (
        .clk(clk), .rst(rst), .x_in(x_in), .x_stage(win)
    );

    evrec_tally u_tally (
        .clk(clk), .rst(rst), .x_new(x_in), .cap(cap),
        .warn_now(fifo_warn), .full_now(full), .tally(tally)
    );

    evrec_format u_fmt (
        .win(win), .tally(tally), .rec(rec)
    );

    evrec_fifo #(.RECS(RECS), .WARN_AT(WARN_AT)) u_fifo (
        .clk(clk), .rst(rst), .push(cap), .push_rec(rec),
        .full(full), .warn(fifo_warn), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

endmodule

// File: tb/evrec_builder_bench.sv
module evrec_builder_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] xid_in;
    logic [2:0]  mode_in;
    logic [9:0]  h1_in, h2_in, et_in, mult_in, mu_in, el_in;
    logic [14:0] rpt_in;
    logic        out_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        fifo_warn;

    always #5 clk = ~clk;

    evrec_builder u_evrec_builder (
        .clk(clk), .rst(rst), .xid_in(xid_in), .mode_in(mode_in),
        .h1_in(h1_in), .h2_in(h2_in), .et_in(et_in), .mult_in(mult_in),
        .mu_in(mu_in), .el_in(el_in), .rpt_in(rpt_in), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .fifo_warn(fifo_warn)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference state: word queue, crossing history (0 = newest), counters
    logic [31:0] wq[$];
    int hid[5], hmode[5], hrpt[5];
    int hv[5][6];
    int c_norm = 0, c_down = 0, c_forc = 0, c_sync = 0, c_derr = 0, c_warn = 0, c_drop = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int idx);
        if (idx <= 1) return "R3";
        if (idx <= 8) return "R4";
        if (idx == 9) return "R9";
        if (idx >= 14 && idx <= 18) return "R5";
        if (idx == 19 || idx == 20) return "R6";
        if (idx >= 21 && idx <= 26) return "R7";
        return "R8";
    endfunction

    task automatic check_outputs();
        int recs;
        int idx;
        recs = (wq.size() + 31) / 32;
        chk("R1", {31'd0, out_valid}, {31'd0, wq.size() > 0});
        chk("R10", {31'd0, fifo_warn}, {31'd0, recs >= 12});
        if (wq.size() > 0) begin
            idx = (32 - (wq.size() % 32)) % 32;
            chk(tag_of(idx), out_data, wq[0]);
            chk("R2", {31'd0, out_last}, {31'd0, (wq.size() % 32) == 1});
        end
    endtask

    task automatic model_step();
        int recs;
        bit mfull, mwarn;
        int nv[6];
        int r;
        int m1, m2;
        logic [31:0] w[32];
        recs  = (wq.size() + 31) / 32;
        mfull = recs >= 16;
        mwarn = recs >= 12;
        if (wq.size() > 0 && out_ready) void'(wq.pop_front());
        if (hrpt[2] & 1) begin
            if (mfull) begin
                c_drop++;
            end else begin
                for (int i = 0; i < 32; i++) w[i] = 0;
                w[0] = hmode[2];
                w[1] = hid[2];
                for (int k = 0; k < 6; k++) w[2+k] = hv[2][k];
                m1 = (hv[2][0] > hv[2][1]) ? hv[2][0] : hv[2][1];
                m2 = (hv[2][4] > hv[2][5]) ? hv[2][4] : hv[2][5];
                w[8] = (m1 > m2) ? m1 : m2;
                w[9] = c_drop;
                for (int k = 0; k < 5; k++) w[14+k] = hrpt[4-k];
                w[19] = (hv[4][2] << 16) | hv[3][2];
                w[20] = (hv[1][2] << 16) | hv[0][2];
                w[21] = c_norm; w[22] = c_down; w[23] = c_forc;
                w[24] = c_sync; w[25] = c_derr; w[26] = c_warn;
                for (int i = 0; i < 32; i++) wq.push_back(w[i]);
            end
            if (mwarn) c_warn++;
        end
        for (int s = 4; s > 0; s--) begin
            hid[s] = hid[s-1]; hmode[s] = hmode[s-1]; hrpt[s] = hrpt[s-1];
            for (int k = 0; k < 6; k++) hv[s][k] = hv[s-1][k];
        end
        nv[0] = h1_in; nv[1] = h2_in; nv[2] = et_in; nv[3] = mult_in; nv[4] = mu_in; nv[5] = el_in;
        r = rpt_in | (mwarn ? 32'h8000 : 0);
        hid[0] = xid_in; hmode[0] = mode_in; hrpt[0] = r;
        for (int k = 0; k < 6; k++) hv[0][k] = nv[k];
        if ((r & 1) && (r & 32'h0AA)) c_norm++;
        if ((r & 1) && (r & 32'h154)) c_down++;
        if ((r & 1) && (r & 32'h200)) c_forc++;
        if (r & 32'h2000) c_sync++;
        if (r & 32'h4000) c_derr++;
    endtask

    task automatic drive(input int rdy_pct, input int dec_pct);
        logic [14:0] rp;
        xid_in  = 12'($urandom);
        mode_in = 3'($urandom);
        h1_in   = 10'($urandom);
        h2_in   = 10'($urandom);
        et_in   = 10'($urandom);
        mult_in = 10'($urandom);
        mu_in   = 10'($urandom);
        el_in   = 10'($urandom);
        rp      = 15'($urandom);
        rp[0]   = ($urandom_range(99) < dec_pct);
        rpt_in  = rp;
        out_ready = ($urandom_range(99) < rdy_pct);
    endtask

    task automatic run_phase(input int n, input int rdy_pct, input int dec_pct);
        for (int i = 0; i < n; i++) begin
            check_outputs();
            drive(rdy_pct, dec_pct);
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int s = 0; s < 5; s++) begin
            hid[s] = 0; hmode[s] = 0; hrpt[s] = 0;
            for (int k = 0; k < 6; k++) hv[s][k] = 0;
        end
        rst = 1'b1;
        xid_in = '0; mode_in = '0; h1_in = '0; h2_in = '0; et_in = '0;
        mult_in = '0; mu_in = '0; el_in = '0; rpt_in = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11", {31'd0, out_valid}, 32'd0);
        chk("R11", {31'd0, fifo_warn}, 32'd0);
        run_phase(900, 80, 3);     // sparse triggers, mostly ready
        run_phase(300, 100, 60);   // back-to-back decisions, neighbours overlap
        run_phase(700, 0, 30);     // blocked sink: warn, full, drops
        run_phase(1500, 50, 2);    // stalls inside records
        run_phase(800, 100, 0);    // drain
        check_outputs();
        // R1 queue empty after drain
        chk("R1", {31'd0, out_valid}, 32'd0);
        finish_run();
    end

endmodule